// File: doc/BRIEF.md
# Circular Buffer Address Generator

This block produces data-memory addresses for nine pointers: eight auxiliary pointers and one coefficient pointer. A pointer can run in linear mode, where its value is the address and an access adds a signed step to it. It can also run in circular mode. There the pointer holds an offset that wraps inside a buffer of programmable length, and the address is a programmable start address plus that offset. Because the wrap decision is made in hardware as part of the post-increment, a loop that walks a delay line or a coefficient table needs no compare-and-branch to stay inside its buffer.

Software loads pointers, start addresses, buffer sizes and a mode word through separate write ports. Each write takes effect at the next clock edge. A datapath issues an access strobe with a pointer select and a step. The current address of the selected pointer is presented combinationally, and the pointer advances on the clock edge of the strobe.

Top module: `circ_addr_gen`

## Requirements
- R1: After reset, every pointer, start address, size and mode bit is zero, so `addr_o` reads 0 for every pointer select.
- R2: With a pointer in linear mode, `addr_o` equals the pointer. An access adds the step to the pointer modulo 2^16, and the new value is visible after that clock edge. With neither an access nor a pointer write, no pointer changes.
- R3: With a pointer in circular mode, `addr_o` equals its start address plus its offset, modulo 2^16.
- R4: For a circular access with buffer size N ≥ 2, if offset + step ≥ N the new offset is offset + step − N; otherwise it is offset + step.
- R5: For a circular access with N ≥ 2, if offset + step < 0 the new offset is offset + step + N.
- R6: For a circular access, a buffer size of 0 or 1 sets the offset to 0.
- R7: Start-address register k (0–3) serves pointers 2k and 2k+1, and start register 4 serves the coefficient pointer (select 8).
- R8: With `mode_wdata_i[9]` clear, pointers 0–3 use size register 0, pointers 4–7 use size register 1, and the coefficient pointer uses size register 2.
- R9: With mode bit 9 set, all eight auxiliary pointers use size register 0 and the contents of size register 1 have no effect. The coefficient pointer keeps size register 2.
- R10: Mode bit p (p = 0–8) selects circular addressing for pointer p when it is 1 and linear addressing when it is 0, independently of every other pointer.
- R11: A pointer write to the pointer being accessed in the same cycle wins over the post-increment. A write to a different pointer in the same cycle as an access performs both updates.
- R12: An access with a select of 9–15 returns address 0 and changes no pointer.
- R13: The step is a 4-bit two's-complement value from −8 to +7.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ptr_we_i | input | 1 | Pointer write enable |
| ptr_wsel_i | input | 4 | Pointer to write (0–7 auxiliary, 8 coefficient) |
| ptr_wdata_i | input | 16 | Pointer or offset value to write |
| base_we_i | input | 1 | Start-address write enable |
| base_wsel_i | input | 3 | Start-address register index (0–4) |
| base_wdata_i | input | 16 | Start address to write |
| size_we_i | input | 1 | Size write enable |
| size_wsel_i | input | 2 | Size register index (0–2) |
| size_wdata_i | input | 16 | Buffer length in words |
| mode_we_i | input | 1 | Mode word write enable |
| mode_wdata_i | input | 10 | Bits 0–8 circular enables per pointer, bit 9 shared-size mode |
| acc_i | input | 1 | Access strobe; the pointer advances at the clock edge |
| acc_sel_i | input | 4 | Pointer used by the access and by `addr_o` |
| acc_step_i | input | 4 | Signed post-increment step |
| addr_o | output | 16 | Address of the selected pointer |

## Verification
The wrap-range property holds only under two conditions on the inputs. The offset held before a circular access must already lie below the buffer size, and the size must be at least 8, so that a single correction by ±N brings any step from −8 to +7 back into range. The property is gated on exactly those conditions. The directed stimulus writes every offset below its buffer size before a circular access, and it uses steps whose sum overshoots by less than one buffer length. Sizes of 0 and 1 are tested separately under their own rule. The write-priority and no-change properties assume nothing about the data values.

// File: rtl/cag_pkg.sv
package cag_pkg;
  // pointer -> start-address register
  function automatic int unsigned base_idx(int unsigned p, int unsigned naux);
    return (p < naux) ? p / 2 : naux / 2;
  endfunction

  // pointer -> size register; shared mode folds the upper aux group onto 0
  function automatic int unsigned size_idx(int unsigned p, int unsigned naux, bit shared);
    if (p >= naux) return 2;
    if (p < naux / 2 || shared) return 0;
    return 1;
  endfunction
endpackage

// File: rtl/cag_cfg.sv
module cag_cfg
  import cag_pkg::*;
#(
  parameter int AW    = 16,
  parameter int NAUX  = 8,
  parameter int NPTR  = NAUX + 1,
  parameter int NBASE = NAUX / 2 + 1,
  parameter int BSW   = $clog2(NBASE),
  parameter int MW    = NPTR + 1
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     base_we_i,
  input  logic [BSW-1:0]           base_wsel_i,
  input  logic [AW-1:0]            base_wdata_i,
  input  logic                     size_we_i,
  input  logic [1:0]               size_wsel_i,
  input  logic [AW-1:0]            size_wdata_i,
  input  logic                     mode_we_i,
  input  logic [MW-1:0]            mode_wdata_i,
  output logic [NPTR-1:0][AW-1:0]  base_p_o,
  output logic [NPTR-1:0][AW-1:0]  size_p_o,
  output logic [NPTR-1:0]          circ_p_o
);
  localparam int NSIZE = 3;

  logic [NBASE-1:0][AW-1:0] base_q;
  logic [NSIZE-1:0][AW-1:0] size_q;
  logic [MW-1:0]            mode_q;

  for (genvar b = 0; b < NBASE; b++) begin : g_base
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                    base_q[b] <= '0;
      else if (base_we_i && base_wsel_i == BSW'(b))   base_q[b] <= base_wdata_i;
    end
  end

  for (genvar s = 0; s < NSIZE; s++) begin : g_size
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                    size_q[s] <= '0;
      else if (size_we_i && size_wsel_i == 2'(s))     size_q[s] <= size_wdata_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        mode_q <= '0;
    else if (mode_we_i) mode_q <= mode_wdata_i;
  end

  for (genvar p = 0; p < NPTR; p++) begin : g_route
    localparam int unsigned BI  = base_idx(p, NAUX);
    localparam int unsigned SI0 = size_idx(p, NAUX, 1'b0);
    localparam int unsigned SI1 = size_idx(p, NAUX, 1'b1);
    assign base_p_o[p] = base_q[BI];
    assign size_p_o[p] = mode_q[MW-1] ? size_q[SI1] : size_q[SI0];
    assign circ_p_o[p] = mode_q[p];
  end
endmodule

// File: rtl/cag_ptr.sv
module cag_ptr #(
  parameter int AW     = 16,
  parameter int STEP_W = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [AW-1:0]     wr_data_i,
  input  logic              adv_i,
  input  logic [STEP_W-1:0] step_i,
  input  logic              circ_i,
  input  logic [AW-1:0]     size_i,
  input  logic [AW-1:0]     base_i,
  output logic [AW-1:0]     ptr_o,
  output logic [AW-1:0]     addr_o
);
  localparam int XW = AW + 2;

  logic [AW-1:0] ptr_q, ptr_nxt, circ_nxt;
  logic [XW-1:0] step_x, size_x, sum_x, wrap_x;

  assign step_x = {{(XW-STEP_W){step_i[STEP_W-1]}}, step_i};
  assign size_x = {2'b00, size_i};
  assign sum_x  = {2'b00, ptr_q} + step_x;

  always_comb begin
    if (sum_x[XW-1])        wrap_x = sum_x + size_x;  // below zero
    else if (sum_x >= size_x) wrap_x = sum_x - size_x;
    else                    wrap_x = sum_x;
    circ_nxt = (size_i < AW'(2)) ? '0 : wrap_x[AW-1:0];
    ptr_nxt  = circ_i ? circ_nxt : sum_x[AW-1:0];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      ptr_q <= '0;
    else if (wr_en_i) ptr_q <= wr_data_i;
    else if (adv_i)   ptr_q <= ptr_nxt;
  end

  assign ptr_o  = ptr_q;
  assign addr_o = circ_i ? base_i + ptr_q : ptr_q;
endmodule

// File: rtl/circ_addr_gen.sv
module circ_addr_gen #(
  parameter int AW     = 16,
  parameter int NAUX   = 8,
  parameter int STEP_W = 4,
  parameter int NPTR   = NAUX + 1,
  parameter int SEL_W  = $clog2(NPTR),
  parameter int BSW    = $clog2(NAUX / 2 + 1),
  parameter int MW     = NPTR + 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ptr_we_i,
  input  logic [SEL_W-1:0]  ptr_wsel_i,
  input  logic [AW-1:0]     ptr_wdata_i,
  input  logic              base_we_i,
  input  logic [BSW-1:0]    base_wsel_i,
  input  logic [AW-1:0]     base_wdata_i,
  input  logic              size_we_i,
  input  logic [1:0]        size_wsel_i,
  input  logic [AW-1:0]     size_wdata_i,
  input  logic              mode_we_i,
  input  logic [MW-1:0]     mode_wdata_i,
  input  logic              acc_i,
  input  logic [SEL_W-1:0]  acc_sel_i,
  input  logic [STEP_W-1:0] acc_step_i,
  output logic [AW-1:0]     addr_o
);
  logic [NPTR-1:0][AW-1:0] base_p, eff_size, ptr_q, addr_p;
  logic [NPTR-1:0]         circ_en;
  logic                    sel_ok;

  cag_cfg #(.AW(AW), .NAUX(NAUX), .NPTR(NPTR), .NBASE(NAUX / 2 + 1), .BSW(BSW), .MW(MW)) u_cfg (
    .clk_i, .rst_ni,
    .base_we_i, .base_wsel_i, .base_wdata_i,
    .size_we_i, .size_wsel_i, .size_wdata_i,
    .mode_we_i, .mode_wdata_i,
    .base_p_o (base_p),
    .size_p_o (eff_size),
    .circ_p_o (circ_en)
  );

  for (genvar p = 0; p < NPTR; p++) begin : g_ptr
    cag_ptr #(.AW(AW), .STEP_W(STEP_W)) u_ptr (
      .clk_i, .rst_ni,
      .wr_en_i   (ptr_we_i && ptr_wsel_i == SEL_W'(p)),
      .wr_data_i (ptr_wdata_i),
      .adv_i     (acc_i && acc_sel_i == SEL_W'(p)),
      .step_i    (acc_step_i),
      .circ_i    (circ_en[p]),
      .size_i    (eff_size[p]),
      .base_i    (base_p[p]),
      .ptr_o     (ptr_q[p]),
      .addr_o    (addr_p[p])
    );
  end

  assign sel_ok = acc_sel_i < SEL_W'(NPTR);
  assign addr_o = sel_ok ? addr_p[acc_sel_i] : '0;
endmodule

// File: rtl/cag_checker.sv
module cag_checker #(
  parameter int AW     = 16,
  parameter int NPTR   = 9,
  parameter int STEP_W = 4,
  parameter int SEL_W  = 4
) (
  input logic                    clk_i,
  input logic                    rst_ni,
  input logic                    acc_i,
  input logic [SEL_W-1:0]        acc_sel_i,
  input logic [STEP_W-1:0]       acc_step_i,
  input logic                    ptr_we_i,
  input logic [SEL_W-1:0]        ptr_wsel_i,
  input logic [AW-1:0]           ptr_wdata_i,
  input logic [NPTR-1:0][AW-1:0] ptr_q,
  input logic [NPTR-1:0][AW-1:0] eff_size,
  input logic [NPTR-1:0]         circ_en
);
  logic          ok, clash, c_sel;
  logic [AW-1:0] p_sel, s_sel, step_x;

  assign ok     = acc_sel_i < SEL_W'(NPTR);
  assign clash  = ptr_we_i && ptr_wsel_i == acc_sel_i;
  assign p_sel  = ok ? ptr_q[acc_sel_i] : '0;
  assign s_sel  = ok ? eff_size[acc_sel_i] : '0;
  assign c_sel  = ok ? circ_en[acc_sel_i] : 1'b0;
  assign step_x = {{(AW-STEP_W){acc_step_i[STEP_W-1]}}, acc_step_i};

  p_lin_step_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    acc_i && ok && !c_sel && !clash |=> ptr_q[$past(acc_sel_i)] == $past(p_sel + step_x));

  p_idle_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !acc_i && !ptr_we_i |=> $stable(ptr_q));

  // R4 and R5: one correction keeps the offset inside the buffer
  p_circ_range_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    acc_i && ok && c_sel && !clash && s_sel >= AW'(8) && p_sel < s_sel
    |=> ptr_q[$past(acc_sel_i)] < $past(s_sel));

  p_small_zero_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    acc_i && ok && c_sel && !clash && s_sel < AW'(2) |=> ptr_q[$past(acc_sel_i)] == '0);

  p_wr_wins_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ptr_we_i && ptr_wsel_i < SEL_W'(NPTR) |=> ptr_q[$past(ptr_wsel_i)] == $past(ptr_wdata_i));

  p_bad_sel_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    acc_i && !ok && !ptr_we_i |=> $stable(ptr_q));
endmodule

bind circ_addr_gen cag_checker #(.AW(AW), .NPTR(NPTR), .STEP_W(STEP_W), .SEL_W(SEL_W)) u_cag_chk (
  .clk_i, .rst_ni, .acc_i, .acc_sel_i, .acc_step_i,
  .ptr_we_i, .ptr_wsel_i, .ptr_wdata_i,
  .ptr_q(ptr_q), .eff_size(eff_size), .circ_en(circ_en)
);

// File: tb/circ_addr_gen_bench.sv
module circ_addr_gen_bench;
  localparam int CLK_P = 10;

  logic        clk = 0, rst_n = 0;
  logic        ptr_we = 0, base_we = 0, size_we = 0, mode_we = 0, acc = 0;
  logic [3:0]  ptr_wsel = 0, acc_sel = 0, acc_step = 0;
  logic [2:0]  base_wsel = 0;
  logic [1:0]  size_wsel = 0;
  logic [15:0] ptr_wdata = 0, base_wdata = 0, size_wdata = 0, addr;
  logic [9:0]  mode_wdata = 0;
  int n_chk = 0, n_fail = 0;

  always #(CLK_P / 2) clk = ~clk;

  circ_addr_gen u_circ_addr_gen (
    .clk_i(clk), .rst_ni(rst_n),
    .ptr_we_i(ptr_we), .ptr_wsel_i(ptr_wsel), .ptr_wdata_i(ptr_wdata),
    .base_we_i(base_we), .base_wsel_i(base_wsel), .base_wdata_i(base_wdata),
    .size_we_i(size_we), .size_wsel_i(size_wsel), .size_wdata_i(size_wdata),
    .mode_we_i(mode_we), .mode_wdata_i(mode_wdata),
    .acc_i(acc), .acc_sel_i(acc_sel), .acc_step_i(acc_step),
    .addr_o(addr)
  );

  task automatic chk(string req, logic [15:0] act, logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr_ptr(int s, logic [15:0] d);
    @(negedge clk); ptr_we = 1; ptr_wsel = 4'(s); ptr_wdata = d;
    @(negedge clk); ptr_we = 0;
  endtask
  task automatic wr_base(int s, logic [15:0] d);
    @(negedge clk); base_we = 1; base_wsel = 3'(s); base_wdata = d;
    @(negedge clk); base_we = 0;
  endtask
  task automatic wr_size(int s, logic [15:0] d);
    @(negedge clk); size_we = 1; size_wsel = 2'(s); size_wdata = d;
    @(negedge clk); size_we = 0;
  endtask
  task automatic wr_mode(logic [9:0] d);
    @(negedge clk); mode_we = 1; mode_wdata = d;
    @(negedge clk); mode_we = 0;
  endtask
  // current address before the post-increment
  task automatic access(int s, logic [3:0] st, string req, logic [15:0] exp);
    @(negedge clk); acc = 1; acc_sel = 4'(s); acc_step = st;
    #1 chk(req, addr, exp);
    @(negedge clk); acc = 0;
  endtask
  task automatic peek(int s, string req, logic [15:0] exp);
    acc = 0; acc_sel = 4'(s);
    #1 chk(req, addr, exp);
  endtask

  task automatic t_reset;
    for (int i = 0; i < 9; i++) peek(i, "R1 reset address", 16'h0);
  endtask

  task automatic t_linear;
    wr_mode(10'h000);
    wr_ptr(3, 16'd100);
    access(3, 4'd3, "R2 linear addr", 16'd100);
    peek(3, "R2 linear +3", 16'd103);
    access(3, 4'h8, "R13 linear addr", 16'd103);
    peek(3, "R13 step -8", 16'd95);
    wr_ptr(5, 16'hFFFE);
    access(5, 4'd7, "R2 linear addr", 16'hFFFE);
    peek(5, "R2 linear modulo wrap", 16'h0005);
  endtask

  task automatic t_circ_fwd;
    wr_mode(10'h002);
    wr_base(0, 16'h1000);
    wr_size(0, 16'd5);
    wr_ptr(1, 16'd3);
    access(1, 4'd1, "R3 circular addr", 16'h1003);
    access(1, 4'd2, "R3 circular addr", 16'h1004);
    peek(1, "R4 forward wrap", 16'h1001);
  endtask

  task automatic t_circ_neg;
    wr_ptr(1, 16'd1);
    access(1, 4'hD, "R3 circular addr", 16'h1001);
    peek(1, "R5 negative wrap -3", 16'h1003);
    wr_ptr(1, 16'd0);
    access(1, 4'hF, "R3 circular addr", 16'h1000);
    peek(1, "R5 negative wrap -1", 16'h1004);
  endtask

  task automatic t_size_small;
    wr_mode(10'h004);
    wr_base(1, 16'h2000);
    wr_size(0, 16'd1);
    wr_ptr(2, 16'd4);
    access(2, 4'd3, "R6 addr before", 16'h2004);
    peek(2, "R6 size 1 clears offset", 16'h2000);
    wr_size(0, 16'd0);
    wr_ptr(2, 16'd3);
    access(2, 4'hF, "R6 addr before", 16'h2003);
    peek(2, "R6 size 0 clears offset", 16'h2000);
  endtask

  task automatic t_base_share;
    wr_mode(10'h143);
    wr_base(0, 16'h3000);
    wr_base(3, 16'h4000);
    wr_base(4, 16'h5000);
    wr_ptr(0, 16'd2);
    wr_ptr(1, 16'd1);
    wr_ptr(6, 16'd0);
    wr_ptr(8, 16'd0);
    peek(0, "R7 pointer 0 start 0", 16'h3002);
    peek(1, "R7 pointer 1 start 0", 16'h3001);
    peek(6, "R7 pointer 6 start 3", 16'h4000);
    peek(8, "R7 coef start 4", 16'h5000);
    wr_base(0, 16'h3100);
    peek(1, "R7 shared start update", 16'h3101);
  endtask

  task automatic t_size_group;
    wr_mode(10'h128);
    wr_size(0, 16'd10);
    wr_size(1, 16'd4);
    wr_size(2, 16'd6);
    wr_base(2, 16'h6000);
    wr_ptr(3, 16'd8);
    access(3, 4'd1, "R8 addr", 16'h2008);
    peek(3, "R8 size 0 no wrap", 16'h2009);
    access(3, 4'd1, "R8 addr", 16'h2009);
    peek(3, "R8 size 0 wrap", 16'h2000);
    wr_ptr(5, 16'd3);
    access(5, 4'd2, "R8 addr", 16'h6003);
    peek(5, "R8 size 1 wrap", 16'h6001);
    wr_ptr(8, 16'd5);
    access(8, 4'd1, "R8 addr", 16'h5005);
    peek(8, "R8 size 2 wrap", 16'h5000);
  endtask

  task automatic t_compat;
    wr_mode(10'h220);
    wr_ptr(5, 16'd3);
    access(5, 4'd2, "R9 addr", 16'h6003);
    peek(5, "R9 shared size 0", 16'h6005);
    wr_size(1, 16'd3);
    access(5, 4'd2, "R9 addr", 16'h6005);
    peek(5, "R9 size 1 ignored", 16'h6007);
  endtask

  task automatic t_mode_bits;
    wr_mode(10'h020);
    wr_ptr(4, 16'd7);
    wr_ptr(5, 16'd1);
    peek(4, "R10 linear beside circular", 16'h0007);
    peek(5, "R10 circular beside linear", 16'h6001);
    wr_mode(10'h010);
    peek(4, "R10 pointer 4 now circular", 16'h6007);
    peek(5, "R10 pointer 5 now linear", 16'h0001);
  endtask

  task automatic t_collision;
    wr_mode(10'h000);
    wr_ptr(2, 16'd10);
    @(negedge clk);
    acc = 1; acc_sel = 4'd2; acc_step = 4'd1;
    ptr_we = 1; ptr_wsel = 4'd2; ptr_wdata = 16'd50;
    @(negedge clk); acc = 0; ptr_we = 0;
    peek(2, "R11 write wins", 16'd50);
    @(negedge clk);
    acc = 1; acc_sel = 4'd2; acc_step = 4'd1;
    ptr_we = 1; ptr_wsel = 4'd3; ptr_wdata = 16'd77;
    @(negedge clk); acc = 0; ptr_we = 0;
    peek(2, "R11 access beside write", 16'd51);
    peek(3, "R11 write beside access", 16'd77);
  endtask

  task automatic t_invalid;
    wr_mode(10'h000);
    for (int i = 0; i < 9; i++) wr_ptr(i, 16'h0100 + 16'(i));
    access(12, 4'd1, "R12 bad select addr", 16'h0000);
    access(9, 4'd7, "R12 bad select addr", 16'h0000);
    for (int i = 0; i < 9; i++) peek(i, "R12 pointers unchanged", 16'h0100 + 16'(i));
  endtask

  initial begin
    #(CLK_P * 100000);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset;
    rst_n = 1;
    @(negedge clk);
    t_reset;
    t_linear;
    t_circ_fwd;
    t_circ_neg;
    t_size_small;
    t_base_share;
    t_size_group;
    t_compat;
    t_mode_bits;
    t_collision;
    t_invalid;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule